// File: doc/BRIEF.md
# Row-to-Row Operand Router

This block carries results from a row of M producing units to the operand inputs of the M units in the next row. Each destination unit has two operand ports, A and B, so the output side has 2M lanes: lane 2j is operand A of destination j and lane 2j+1 is operand B. A source can reach any destination within R = (N-1)/2 positions of its own index, where N is the odd neighbourhood width. One source may feed several operand ports in the same cycle.

The router is a pipeline of N register layers. Layer 0 has one injection cell per source. Each injection cell places its source on the A lane, the B lane, both lanes or neither lane of the destination with the same index. Layers 1 to 2R are made of 2x2 switch cells. Odd layers pair lanes (2k+1, 2k+2), and the two outermost lanes pass straight through. Even layers pair lanes (2k, 2k+1). A cell either keeps both lanes, swaps them, or copies one lane onto both. Each cell holds its own 2-bit setting, written through an address/data port. A token is discarded when a copy overwrites a lane that carries valid data, and that event is reported on an error output.

Top module: `row_router`

## Requirements
- R1: While rst_ni is low, and right after it is released, all dst_v_o bits and err_o are 0, and every cell setting is 2'b00.
- R2: With every cell at 2'b00, a token presented on source i appears on lane 2i (operand A of destination i), with its data, exactly N cycles later. Lane 2i+1 stays invalid.
- R3: Injection cell i is at address i. Code 00 drives lane 2i, 01 drives lane 2i+1, 10 drives both lanes and 11 drives neither. In every case the token is the source's valid and data.
- R4: Switch cell codes: 00 keeps each lane on its own position, 01 swaps the two lanes, 10 copies the lower-numbered lane onto both, and 11 copies the higher-numbered lane onto both. Odd layers pair lanes (2k+1, 2k+2) and even layers pair lanes (2k, 2k+1).
- R5: Through its settings, source i can reach operand A or B of every destination j with |i-j| <= R that lies inside 0..M-1.
- R6: A new set of source tokens is accepted on every clock cycle. Tokens of consecutive cycles leave in consecutive cycles and never mix.
- R7: Addresses are assigned as follows. Injection cells use 0..M-1. Odd layer l uses M+((l-1)/2)(2M-1)+k for k in 0..M-2. Even layer l uses M+((l-2)/2)(2M-1)+(M-1)+k for k in 0..M-1. A write sets the cell on the next clock edge. Writes to addresses at or above the cell count change nothing.
- R8: When a copy code discards a valid token on the other lane of a switch cell in layer l, err_o is 1 in the cycle l+1 cycles after that token entered. Otherwise err_o is 0.
- R9: In odd layers, lane 0 and lane 2M-1 pass through unchanged, with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_v_i | input | M | Valid bit per source |
| src_d_i | input | M*DW | Source data, source i at bits i*DW +: DW |
| cfg_we_i | input | 1 | Cell setting write enable |
| cfg_addr_i | input | AW | Cell address |
| cfg_data_i | input | 2 | Cell code |
| dst_v_o | output | 2M | Valid per operand lane (2j = A, 2j+1 = B of destination j) |
| dst_d_o | output | 2M*DW | Data per operand lane, lane j at bits j*DW +: DW |
| err_o | output | 1 | A valid token was discarded by a copy code |

## Verification
The checks on output timing and on the error flag assume one thing about the inputs: cell settings change only while no token is inside the pipeline. Otherwise a token could cross layers set up for different routes, and the reference prediction would no longer apply. The stimulus therefore sends N+1 idle cycles before every group of writes and sends no source traffic during writes. The random phase draws every cell code freely, so discards and multi-lane fan-out occur often and are predicted rather than avoided.

// File: rtl/orn_pkg.sv
package orn_pkg;
  typedef enum logic [1:0] {
    HC_A    = 2'b00,
    HC_B    = 2'b01,
    HC_BOTH = 2'b10,
    HC_NONE = 2'b11
  } hc_mode_e;

  typedef enum logic [1:0] {
    XB_KEEP = 2'b00,
    XB_SWAP = 2'b01,
    XB_LO   = 2'b10,
    XB_HI   = 2'b11
  } xb_mode_e;
endpackage

// File: rtl/orn_cfg_regs.sv
module orn_cfg_regs #(
  parameter int NCELL = 11,
  parameter int AW    = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [1:0]            data_i,
  output logic [NCELL-1:0][1:0] cfg_o
);
  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_o[c] <= 2'b00;
      else if (we_i && addr_i == AW'(c))        cfg_o[c] <= data_i;
    end
  end
endmodule

// File: rtl/orn_half_cell.sv
module orn_half_cell
  import orn_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          v_i,
  input  logic [DW-1:0] d_i,
  output logic          a_v_o,
  output logic [DW-1:0] a_d_o,
  output logic          b_v_o,
  output logic [DW-1:0] b_d_o
);
  logic a_n, b_n;

  always_comb begin
    unique case (hc_mode_e'(mode_i))
      HC_A:    {a_n, b_n} = {v_i, 1'b0};
      HC_B:    {a_n, b_n} = {1'b0, v_i};
      HC_BOTH: {a_n, b_n} = {v_i, v_i};
      default: {a_n, b_n} = 2'b00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_v_o <= 1'b0;
      b_v_o <= 1'b0;
      a_d_o <= '0;
      b_d_o <= '0;
    end else begin
      a_v_o <= a_n;
      b_v_o <= b_n;
      a_d_o <= d_i;
      b_d_o <= d_i;
    end
  end
endmodule

// File: rtl/orn_xbar_cell.sv
module orn_xbar_cell
  import orn_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          lo_v_i,
  input  logic [DW-1:0] lo_d_i,
  input  logic          hi_v_i,
  input  logic [DW-1:0] hi_d_i,
  output logic          lo_v_o,
  output logic [DW-1:0] lo_d_o,
  output logic          hi_v_o,
  output logic [DW-1:0] hi_d_o,
  output logic          drop_o
);
  logic          lo_v_n, hi_v_n;
  logic [DW-1:0] lo_d_n, hi_d_n;

  always_comb begin
    drop_o = 1'b0;
    unique case (xb_mode_e'(mode_i))
      XB_KEEP: begin
        {lo_v_n, lo_d_n} = {lo_v_i, lo_d_i};
        {hi_v_n, hi_d_n} = {hi_v_i, hi_d_i};
      end
      XB_SWAP: begin
        {lo_v_n, lo_d_n} = {hi_v_i, hi_d_i};
        {hi_v_n, hi_d_n} = {lo_v_i, lo_d_i};
      end
      XB_LO: begin
        {lo_v_n, lo_d_n} = {lo_v_i, lo_d_i};
        {hi_v_n, hi_d_n} = {lo_v_i, lo_d_i};
        drop_o = hi_v_i;
      end
      default: begin
        {lo_v_n, lo_d_n} = {hi_v_i, hi_d_i};
        {hi_v_n, hi_d_n} = {hi_v_i, hi_d_i};
        drop_o = lo_v_i;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_v_o <= 1'b0;
      hi_v_o <= 1'b0;
      lo_d_o <= '0;
      hi_d_o <= '0;
    end else begin
      lo_v_o <= lo_v_n;
      hi_v_o <= hi_v_n;
      lo_d_o <= lo_d_n;
      hi_d_o <= hi_d_n;
    end
  end
endmodule

// File: rtl/row_router.sv
module row_router #(
  parameter int M  = 4,
  parameter int N  = 3,
  parameter int DW = 8,
  localparam int R     = (N - 1) / 2,
  localparam int NL    = 2 * R,
  localparam int NLANE = 2 * M,
  localparam int NCELL = M + R * (2 * M - 1),
  localparam int AW    = $clog2(NCELL)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [M-1:0]        src_v_i,
  input  logic [M*DW-1:0]     src_d_i,
  input  logic                cfg_we_i,
  input  logic [AW-1:0]       cfg_addr_i,
  input  logic [1:0]          cfg_data_i,
  output logic [NLANE-1:0]    dst_v_o,
  output logic [NLANE*DW-1:0] dst_d_o,
  output logic                err_o
);
  logic [NCELL-1:0][1:0] cfg_q;
  logic                  lv   [NL+1][NLANE];
  logic [DW-1:0]         ld   [NL+1][NLANE];
  logic                  drop [NL+1][M];
  logic                  drop_any;

  orn_cfg_regs #(.NCELL(NCELL), .AW(AW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .data_i(cfg_data_i),
    .cfg_o(cfg_q)
  );

  for (genvar k = 0; k < M; k++) begin : g_inj
    orn_half_cell #(.DW(DW)) u_half (
      .clk_i, .rst_ni,
      .mode_i(cfg_q[k]),
      .v_i(src_v_i[k]), .d_i(src_d_i[k*DW +: DW]),
      .a_v_o(lv[0][2*k]),   .a_d_o(ld[0][2*k]),
      .b_v_o(lv[0][2*k+1]), .b_d_o(ld[0][2*k+1])
    );
    assign drop[0][k] = 1'b0;
  end

  for (genvar l = 1; l <= NL; l++) begin : g_layer
    // odd layers: pairs (2k+1,2k+2), edge lanes registered straight through
    localparam int ODD   = l % 2;
    localparam int FIRST = ODD;
    localparam int CNT   = M - ODD;
    localparam int BASE  = ODD ? M + ((l - 1) / 2) * (2 * M - 1)
                               : M + ((l - 2) / 2) * (2 * M - 1) + (M - 1);
    for (genvar k = 0; k < CNT; k++) begin : g_xb
      orn_xbar_cell #(.DW(DW)) u_xb (
        .clk_i, .rst_ni,
        .mode_i(cfg_q[BASE+k]),
        .lo_v_i(lv[l-1][FIRST+2*k]),   .lo_d_i(ld[l-1][FIRST+2*k]),
        .hi_v_i(lv[l-1][FIRST+2*k+1]), .hi_d_i(ld[l-1][FIRST+2*k+1]),
        .lo_v_o(lv[l][FIRST+2*k]),     .lo_d_o(ld[l][FIRST+2*k]),
        .hi_v_o(lv[l][FIRST+2*k+1]),   .hi_d_o(ld[l][FIRST+2*k+1]),
        .drop_o(drop[l][k])
      );
    end
    if (ODD == 1) begin : g_edge
      assign drop[l][M-1] = 1'b0;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lv[l][0]       <= 1'b0;
          lv[l][NLANE-1] <= 1'b0;
          ld[l][0]       <= '0;
          ld[l][NLANE-1] <= '0;
        end else begin
          lv[l][0]       <= lv[l-1][0];
          lv[l][NLANE-1] <= lv[l-1][NLANE-1];
          ld[l][0]       <= ld[l-1][0];
          ld[l][NLANE-1] <= ld[l-1][NLANE-1];
        end
      end
    end
  end

  always_comb begin
    drop_any = 1'b0;
    for (int l = 0; l <= NL; l++)
      for (int k = 0; k < M; k++)
        drop_any = drop_any | drop[l][k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= drop_any;
  end

  for (genvar j = 0; j < NLANE; j++) begin : g_out
    assign dst_v_o[j]           = lv[NL][j];
    assign dst_d_o[j*DW +: DW]  = ld[NL][j];
  end
endmodule

// File: rtl/orn_chk.sv
module orn_chk #(
  parameter int M     = 4,
  parameter int N     = 3,
  parameter int NCELL = 11,
  parameter int AW    = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [M-1:0]          src_v_i,
  input logic [2*M-1:0]        dst_v_o,
  input logic                  err_o,
  input logic                  cfg_we_i,
  input logic [AW-1:0]         cfg_addr_i,
  input logic [1:0]            cfg_data_i,
  input logic [NCELL-1:0][1:0] cfg_q
);
  logic [N-1:0] hist;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist <= '0;
    else         hist <= {hist[N-2:0], |src_v_i};
  end

  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |dst_v_o |-> hist[N-1]);  // R2

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> |hist);  // R8

  AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && int'(cfg_addr_i) < NCELL) |=> cfg_q[$past(cfg_addr_i)] == $past(cfg_data_i));  // R7

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_q));  // R7
endmodule

bind row_router orn_chk #(.M(M), .N(N), .NCELL(NCELL), .AW(AW)) u_chk (
  .clk_i, .rst_ni, .src_v_i, .dst_v_o, .err_o,
  .cfg_we_i, .cfg_addr_i, .cfg_data_i, .cfg_q(cfg_q)
);

// File: tb/tb_row_router.sv
module tb_row_router;
  localparam int M     = 4;
  localparam int N     = 3;
  localparam int DW    = 8;
  localparam int R     = (N - 1) / 2;
  localparam int NL    = 2 * R;
  localparam int NLANE = 2 * M;
  localparam int NCELL = M + R * (2 * M - 1);
  localparam int AW    = $clog2(NCELL);

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [M-1:0]        src_v_i = '0;
  logic [M*DW-1:0]     src_d_i = '0;
  logic                cfg_we_i = 1'b0;
  logic [AW-1:0]       cfg_addr_i = '0;
  logic [1:0]          cfg_data_i = '0;
  logic [NLANE-1:0]    dst_v_o;
  logic [NLANE*DW-1:0] dst_d_o;
  logic                err_o;

  row_router #(.M(M), .N(N), .DW(DW)) dut (.*);

  always #2 clk_i = ~clk_i;  // 250 MHz

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  logic [NLANE-1:0] ev [64];
  logic [DW-1:0]    ed [64][NLANE];
  logic             ee [64];
  logic [1:0]       sh [NCELL];

  function automatic int base_of(int l);
    if (l % 2 == 1) return M + ((l - 1) / 2) * (2 * M - 1);
    return M + ((l - 2) / 2) * (2 * M - 1) + (M - 1);
  endfunction

  task automatic clear_exp();
    for (int s = 0; s < 64; s++) begin
      ev[s] = '0; ee[s] = 1'b0;
      for (int j = 0; j < NLANE; j++) ed[s][j] = '0;
    end
  endtask

  task automatic predict(input logic [M-1:0] v, input logic [M*DW-1:0] d);
    logic          cv [NLANE];
    logic [DW-1:0] cd [NLANE];
    logic          nv [NLANE];
    logic [DW-1:0] nd [NLANE];
    for (int j = 0; j < NLANE; j++) begin cv[j] = 1'b0; cd[j] = '0; end
    for (int i = 0; i < M; i++) begin
      cd[2*i] = d[i*DW +: DW]; cd[2*i+1] = d[i*DW +: DW];
      case (sh[i])
        2'b00: cv[2*i] = v[i];
        2'b01: cv[2*i+1] = v[i];
        2'b10: begin cv[2*i] = v[i]; cv[2*i+1] = v[i]; end
        default: ;
      endcase
    end
    for (int l = 1; l <= NL; l++) begin
      int first, cnt;
      bit dropped;
      dropped = 1'b0;
      for (int j = 0; j < NLANE; j++) begin nv[j] = 1'b0; nd[j] = '0; end
      if (l % 2 == 1) begin
        first = 1; cnt = M - 1;
        nv[0] = cv[0]; nd[0] = cd[0];
        nv[NLANE-1] = cv[NLANE-1]; nd[NLANE-1] = cd[NLANE-1];
      end else begin
        first = 0; cnt = M;
      end
      for (int k = 0; k < cnt; k++) begin
        int a, b;
        a = first + 2 * k; b = a + 1;
        case (sh[base_of(l) + k])
          2'b00: begin nv[a] = cv[a]; nd[a] = cd[a]; nv[b] = cv[b]; nd[b] = cd[b]; end
          2'b01: begin nv[a] = cv[b]; nd[a] = cd[b]; nv[b] = cv[a]; nd[b] = cd[a]; end
          2'b10: begin nv[a] = cv[a]; nd[a] = cd[a]; nv[b] = cv[a]; nd[b] = cd[a];
                       if (cv[b]) dropped = 1'b1; end
          default: begin nv[a] = cv[b]; nd[a] = cd[b]; nv[b] = cv[b]; nd[b] = cd[b];
                       if (cv[a]) dropped = 1'b1; end
        endcase
      end
      if (dropped) ee[(cyc + l + 1) % 64] = 1'b1;
      cv = nv; cd = nd;
    end
    for (int j = 0; j < NLANE; j++) begin
      ev[(cyc + N) % 64][j] = cv[j];
      ed[(cyc + N) % 64][j] = cd[j];
    end
  endtask

  task automatic step(input logic [M-1:0] v, input logic [M*DW-1:0] d,
                      input logic we = 1'b0, input logic [AW-1:0] wa = '0,
                      input logic [1:0] wd = 2'b00);
    int s;
    bit bad;
    logic [NLANE*DW-1:0] xd;
    @(negedge clk_i);
    s = cyc % 64;
    bad = 1'b0;
    xd = '0;
    for (int j = 0; j < NLANE; j++) begin
      xd[j*DW +: DW] = ed[s][j];
      if (ev[s][j] && dst_d_o[j*DW +: DW] !== ed[s][j]) bad = 1'b1;
    end
    if (dst_v_o !== ev[s] || err_o !== ee[s]) bad = 1'b1;
    n_chk++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s cycle %0d: valid %b exp %b, err %b exp %b, data %h exp %h",
               cur_req, cyc, dst_v_o, ev[s], err_o, ee[s], dst_d_o, xd);
    end
    ev[s] = '0; ee[s] = 1'b0;
    src_v_i = v; src_d_i = d;
    cfg_we_i = we; cfg_addr_i = wa; cfg_data_i = wd;
    if (|v) predict(v, d);
    if (we && int'(wa) < NCELL) sh[wa] = wd;
  endtask

  task automatic traffic(input int n, input logic [M-1:0] mask);
    for (int c = 0; c < n; c++) begin
      logic [M*DW-1:0] d;
      for (int i = 0; i < M; i++) d[i*DW +: DW] = DW'($urandom);
      step(M'($urandom) & mask, d);
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) step('0, '0);
  endtask

  task automatic wr(input int a, input logic [1:0] v);
    step('0, '0, 1'b1, AW'(a), v);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    src_v_i = '0; cfg_we_i = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk_i);
      n_chk++;
      if (dst_v_o !== '0 || err_o !== 1'b0) begin
        n_fail++;
        $display("FAIL R1 cycle %0d: valid %b exp 0, err %b exp 0", cyc, dst_v_o, err_o);
      end
    end
    clear_exp();
    for (int c = 0; c < NCELL; c++) sh[c] = 2'b00;
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    cur_req = "R1"; idle(N + 1);

    cur_req = "R2"; traffic(30, '1); idle(N + 1);

    cur_req = "R6"; traffic(40, '1); idle(N + 1);

    // R3: injection codes
    cur_req = "R3";
    wr(0, 2'b10); wr(1, 2'b11); wr(2, 2'b01);
    traffic(25, '1); idle(N + 1);

    // R4/R5: source 0 to operand B of destination 1
    do_reset();
    cur_req = "R5";
    wr(0, 2'b01); wr(base_of(1) + 0, 2'b01); wr(base_of(2) + 1, 2'b01);
    traffic(20, 4'b0011); idle(N + 1);

    // R4: lower-lane copy gives fan-out to two destinations
    cur_req = "R4";
    wr(base_of(2) + 1, 2'b00); wr(base_of(1) + 0, 2'b10);
    traffic(20, 4'b0001); idle(N + 1);

    // R8: copy code discards source 1
    cur_req = "R8";
    step(4'b0011, {M*DW{1'b1}});
    step(4'b0010, '0);
    traffic(20, 4'b0011); idle(N + 2);

    // R9: edge lanes through the odd layer
    do_reset();
    cur_req = "R9";
    wr(M - 1, 2'b01); wr(base_of(2) + M - 1, 2'b11);
    traffic(20, 4'b1001); idle(N + 1);

    // R7: out-of-range writes leave routing unchanged
    cur_req = "R7";
    for (int a = NCELL; a < (1 << AW); a++) wr(a, 2'b11);
    traffic(20, '1); idle(N + 1);

    // random settings
    for (int r = 0; r < 20; r++) begin
      cur_req = "R5";
      for (int c = 0; c < NCELL; c++) wr(c, 2'($urandom));
      traffic(30, '1);
      idle(N + 2);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog %s: expired at cycle %0d, expected completion", cur_req, cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule